// File: doc/BRIEF.md
# Gated Countdown Event Timer

This block is a single-channel countdown timer that software drives over a small synchronous register bus. A control word holds a run enable and an interrupt enable, and it carries a self-clearing bit that acknowledges a pending event. A second register takes a tick count: writing it loads the counter and arms the countdown. The counter steps down once for each cycle in which `tick_en` is high. When an armed countdown reaches zero, a pending flag is raised and the level interrupt output follows that flag through the interrupt enable.

The run enable gates every action. With it cleared, the counter holds its value, new tick counts are refused, and the pending flag cannot change, so an acknowledge is also refused. To acknowledge, software first writes the run enable alone, then writes the run enable together with the clear bit. After that second write the pending flag is clear and the interrupt enable is off. Writing zero to the control word stops the countdown and masks the interrupt. The bus accepts a write in every cycle, with no back-pressure. Read data is combinational from the addressed register.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control word reads 0, the count reads 0, and `irq_out` is 0.
- R2: The control word at offset 0x40 has these bits: bit 0 is the run enable and bit 1 is the interrupt enable, both read/write. Bit 2 reads the pending flag and ignores writes. Bit 4 is the clear action and always reads 0. All other bits read 0.
- R3: A write to the count register at offset 0x44 while the run enable is set loads the written value and arms the countdown. A read of 0x44 returns the remaining count.
- R4: A write to 0x44 while the run enable is clear leaves the count unchanged.
- R5: While the run enable is set, the count drops by one in each cycle that has `tick_en` high and a nonzero count. When the run enable is clear or `tick_en` is low, the count holds.
- R6: One cycle after an armed countdown is at zero with the run enable set, the pending flag sets. The count then holds at zero, and the event does not fire again until the next load.
- R7: `irq_out` is high exactly when the pending flag and the interrupt enable are both set.
- R8: A control write clears the pending flag only when the stored run enable and the written bit 0 are both 1 and bit 4 is 1. Otherwise the pending flag is unchanged.
- R9: The acknowledge sequence (write 0x01, then write 0x11) leaves the pending flag at 0 and the interrupt enable at 0.
- R10: Writing 0 to the control word stops the countdown, forces `irq_out` low, and keeps the pending flag.
- R11: When a count load occurs in the same cycle that an armed zero count would raise the event, the load wins and no event is raised.
- R12: The count register holds the full 32-bit range, and a load of 0xffffffff reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances the countdown by one when high |
| bus_wr | input | 1 | Write strobe, accepted every cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is the cycle in which a load coincides with an armed zero count. The bench loads a count of zero and then, in the very next cycle, writes the count register again, so that the collision lands exactly on that cycle. The gated acknowledge paths are also reached on purpose: a clear is issued with the stored enable off but with bit 0 set in the written word, and the bench checks that it is refused. A behavioural model checks `irq_out` on every cycle and checks each register read.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int EN_BIT   = 0;
  localparam int IEN_BIT  = 1;
  localparam int PEND_BIT = 2;
  localparam int CLR_BIT  = 4;

  typedef struct packed {
    logic ien;
    logic en;
  } cdt_ctrl_t;
endpackage

// File: rtl/cdt_bus_port.sv
module cdt_bus_port
  import cdt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int CTRL_OFS = 'h40,
  parameter int VAL_OFS  = 'h44
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  cdt_ctrl_t         ctrl,
  input  logic              pend,
  input  logic [CNT_W-1:0]  cnt,
  output logic              ctrl_wr,
  output logic              val_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] VAL_A  = ADDR_W'(VAL_OFS);

  logic              hit_ctrl, hit_val;
  logic [DATA_W-1:0] ctrl_word, cnt_word;

  assign hit_ctrl = (bus_addr == CTRL_A);
  assign hit_val  = (bus_addr == VAL_A);
  assign ctrl_wr  = bus_wr && hit_ctrl;
  assign val_wr   = bus_wr && hit_val;

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign cnt_word = {{(DATA_W-CNT_W){1'b0}}, cnt};
    end else begin : g_full
      assign cnt_word = cnt[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[EN_BIT]   = ctrl.en;
    ctrl_word[IEN_BIT]  = ctrl.ien;
    ctrl_word[PEND_BIT] = pend;
  end

  always_comb begin
    if (hit_ctrl)     bus_rdata = ctrl_word;
    else if (hit_val) bus_rdata = cnt_word;
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/cdt_ctrl_reg.sv
module cdt_ctrl_reg
  import cdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctrl_wr,
  input  logic      wr_en,
  input  logic      wr_ien,
  input  logic      wr_clr,
  output cdt_ctrl_t ctrl,
  output logic      clr_ok
);
  // acknowledge needs the enable both already stored and in the written word
  assign clr_ok = ctrl_wr && ctrl.en && wr_en && wr_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl.en  <= wr_en;
      ctrl.ien <= wr_ien;
    end
  end
endmodule

// File: rtl/cdt_countdown.sv
module cdt_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic armed;
  logic load;
  logic at_zero;

  assign load    = val_wr && run;
  assign at_zero = (cnt == '0);
  // a load in the same cycle suppresses the event
  assign expire  = run && armed && at_zero && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (load) begin
        cnt   <= load_val;
        armed <= 1'b1;
      end else begin
        if (run && tick_en && !at_zero) cnt <= cnt - 1'b1;
        if (expire) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cdt_pending.sv
module cdt_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_ok,
  input  logic ien,
  output logic pend,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pend <= 1'b0;
    else if (expire) pend <= 1'b1;
    else if (clr_ok) pend <= 1'b0;
  end

  assign irq = pend && ien;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int CTRL_OFS = 'h40,
  parameter int VAL_OFS  = 'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  cdt_ctrl_t        ctrl_q;
  logic             ctrl_wr, val_wr, clr_ok, expire, pend_q;
  logic [CNT_W-1:0] cnt_q;

  cdt_bus_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CTRL_OFS(CTRL_OFS), .VAL_OFS(VAL_OFS)
  ) u_bus (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .ctrl(ctrl_q), .pend(pend_q),
    .cnt(cnt_q), .ctrl_wr(ctrl_wr), .val_wr(val_wr), .bus_rdata(bus_rdata)
  );

  cdt_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .wr_en(bus_wdata[EN_BIT]), .wr_ien(bus_wdata[IEN_BIT]),
    .wr_clr(bus_wdata[CLR_BIT]), .ctrl(ctrl_q), .clr_ok(clr_ok)
  );

  cdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .tick_en(tick_en),
    .val_wr(val_wr), .load_val(bus_wdata[CNT_W-1:0]),
    .cnt(cnt_q), .expire(expire)
  );

  cdt_pending u_pend (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_ok(clr_ok),
    .ien(ctrl_q.ien), .pend(pend_q), .irq(irq_out)
  );
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             en,
  input logic             ien,
  input logic             pend,
  input logic             val_wr,
  input logic [CNT_W-1:0] cnt,
  input logic             irq_out
);
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend && ien));

  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick_en && cnt != '0 && !val_wr) |=> (cnt == $past(cnt) - 1'b1));

  assert_rise_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> (cnt == '0));

  assert_clear_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !en) |=> pend);

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (val_wr && en && !pend) |=> !pend);
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .en(ctrl_q.en),
  .ien(ctrl_q.ien), .pend(pend_q), .val_wr(val_wr), .cnt(cnt_q),
  .irq_out(irq_out)
);

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
  localparam logic [7:0] A_CTRL = 8'h40;
  localparam logic [7:0] A_VAL  = 8'h44;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_cnt;
  bit m_en, m_ien, m_pend, m_armed;

  always #5 clk = ~clk;

  cdt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  always @(posedge clk) begin
    bit ld, fire, cw;
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_ien = 0; m_pend = 0; m_armed = 0;
    end else begin
      ld   = bus_wr && bus_addr == A_VAL && m_en;
      cw   = bus_wr && bus_addr == A_CTRL;
      fire = m_en && m_armed && m_cnt == 0 && !ld;
      if (fire) m_pend = 1;
      else if (cw && m_en && bus_wdata[0] && bus_wdata[4]) m_pend = 0;
      if (ld) begin m_cnt = bus_wdata; m_armed = 1; end
      else begin
        if (m_en && tick_en && m_cnt != 0) m_cnt = m_cnt - 1;
        if (fire) m_armed = 0;
      end
      if (cw) begin m_en = bus_wdata[0]; m_ien = bus_wdata[1]; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R7: irq level compared to the model on every cycle
  always @(negedge clk) if (rst_n && !done) chk("R7 irq", {31'b0, irq_out}, {31'b0, m_pend && m_ien});

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    logic [31:0] exp;
    bus_addr = a;
    #1;
    if (a == A_CTRL) exp = {29'b0, m_pend, m_ien, m_en};
    else if (a == A_VAL) exp = m_cnt;
    else exp = 0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    rd("R1 ctrl", A_CTRL); chk("R1 ctrl zero", bus_rdata, 0);
    rd("R1 count", A_VAL); chk("R1 count zero", bus_rdata, 0);
    chk("R1 irq", {31'b0, irq_out}, 0);
    // R4 load refused while disabled
    wr(A_VAL, 5); rd("R4 count", A_VAL); chk("R4 unchanged", bus_rdata, 0);
    // R2 control bits, clear reads 0
    wr(A_CTRL, 32'h3); rd("R2 ctrl", A_CTRL); chk("R2 en+ien", bus_rdata, 3);
    wr(A_CTRL, 32'h13); rd("R2 clr reads 0", A_CTRL); chk("R2 bit4", bus_rdata, 3);
    wr(A_CTRL, 32'hFFE7); rd("R2 other bits", A_CTRL);
    wr(A_CTRL, 32'h3);
    // R3, R5, R6 straight countdown
    tick_en = 1;
    wr(A_VAL, 4); rd("R3 count", A_VAL);
    for (int i = 0; i < 6; i++) begin idle(1); rd("R5 countdown", A_VAL); rd("R6 ctrl", A_CTRL); end
    chk("R6 irq raised", {31'b0, irq_out}, 1);
    // R6 no refire while held at zero
    wr(A_CTRL, 32'h1); wr(A_CTRL, 32'h13);
    idle(5); rd("R6 no refire", A_CTRL); chk("R6 pend stays 0", bus_rdata, 3);
    // R5 gapped ticks
    wr(A_VAL, 10);
    for (int i = 0; i < 12; i++) begin tick_en = i[0]; idle(1); rd("R5 gapped", A_VAL); end
    tick_en = 1;
    idle(12); rd("R6 pending", A_CTRL);
    // R9 acknowledge sequence
    wr(A_CTRL, 32'h1); wr(A_CTRL, 32'h11);
    rd("R9 ctrl", A_CTRL); chk("R9 pend0 ien0", bus_rdata, 1);
    // R10 stop keeps pending, masks irq
    wr(A_CTRL, 32'h3); wr(A_VAL, 2); idle(4);
    rd("R10 pre", A_CTRL);
    wr(A_CTRL, 32'h0); rd("R10 stop", A_CTRL); chk("R10 pend kept", bus_rdata, 4);
    chk("R10 irq low", {31'b0, irq_out}, 0);
    // R8 clears refused without stored enable
    wr(A_CTRL, 32'h10); rd("R8 clr en0", A_CTRL); chk("R8 ignored", bus_rdata, 4);
    wr(A_CTRL, 32'h13); rd("R8 clr stored0", A_CTRL); chk("R8 stored en gate", bus_rdata, 7);
    wr(A_CTRL, 32'h12); rd("R8 clr bit0 0", A_CTRL); chk("R8 written en gate", bus_rdata, 6);
    wr(A_CTRL, 32'h3); wr(A_CTRL, 32'h13); rd("R8 clr ok", A_CTRL); chk("R8 cleared", bus_rdata, 3);
    // R4/R5 hold while disabled
    wr(A_VAL, 50); idle(3); wr(A_CTRL, 32'h2);
    wr(A_VAL, 9); idle(5); rd("R4 held", A_VAL); rd("R5 held", A_VAL);
    // R11 load collides with zero event
    wr(A_CTRL, 32'h3);
    wr(A_VAL, 0); wr(A_VAL, 7);
    rd("R11 ctrl", A_CTRL); chk("R11 no event", bus_rdata, 3);
    rd("R11 count", A_VAL);
    // R12 full range
    tick_en = 0;
    wr(A_VAL, 32'hFFFF_FFFF); rd("R12 max", A_VAL); chk("R12 readback", bus_rdata, 32'hFFFF_FFFF);
    tick_en = 1; idle(3); rd("R12 step", A_VAL); chk("R12 after ticks", bus_rdata, 32'hFFFF_FFFC);
    idle(2);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule